// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Array

This block models the output stage of a small sum-of-products programmable logic device. Each of its cells receives one sum term and one dedicated enable product term from an AND array outside the block. It drives a pin value and a pin tri-state enable, and it returns one feedback signal into the array. A cell can work as a registered output, a combinational output, a combinational I/O, or a dedicated input. Two global bits and two per-cell bits choose the mode and the polarity.

The wrapper holds `N_CELL` cells (eight by default) and routes the neighbour pins. A cell in the lower half takes the pin just below it as its neighbour. A cell in the upper half takes the pin just above it. The two end cells have no such neighbour. The lowest cell takes the global output-enable pin instead, and the highest cell takes the clock pin. In the end cells, the feedback select is driven by the register-permit bit instead of the family bit.

Top module: `pmc_array`

## Requirements
- R1: Each cell's D register loads its sum term on every rising clock edge. When `rst` is high at an edge, the register loads 0 instead.
- R2: When `reg_en`=1 and {`fam_reg`,`sl_mode[i]`}=2'b10, the cell is registered. The pin value is the register output when `sl_pol[i]`=1 and its inverse when `sl_pol[i]`=0. The enable is high exactly when `oe_n` is low.
- R3: With {`fam_reg`,`sl_mode[i]`}=2'b11, the cell is a combinational I/O. The pin value is `sum_term[i]` XOR NOT `sl_pol[i]`, and the enable follows `oe_term[i]`.
- R4: With {`fam_reg`,`sl_mode[i]`}=2'b00, or 2'b10 while `reg_en`=0, the cell is a combinational output. The pin value is `sum_term[i]` XOR NOT `sl_pol[i]`, and the enable is always high.
- R5: With {`fam_reg`,`sl_mode[i]`}=2'b01, the cell is a dedicated input and its enable is always low.
- R6: For a cell that is not at an end, feedback is selected by its effective mode. Registered (R2) feeds back the inverted register output. Combinational I/O feeds back `pin_in[i]`. Combinational output feeds back 0. Dedicated input feeds back `pin_in[i-1]` when i < N_CELL/2 and `pin_in[i+1]` otherwise.
- R7: For cells 0 and N_CELL-1, feedback is selected by {`reg_en`,`sl_mode[i]`}. 2'b10 feeds back the inverted register output, 2'b11 feeds back `pin_in[i]`, and 2'b00 feeds back 0. 2'b01 feeds back `oe_n` for cell 0 and `clk` for cell N_CELL-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock pin; also the neighbour input of the highest cell |
| rst | input | 1 | Synchronous active-high reset of the cell registers |
| reg_en | input | 1 | Global bit: registers permitted; feedback select of end cells |
| fam_reg | input | 1 | Global bit: registered-family (1) or combinational-family (0) |
| sl_mode | input | N_CELL | Per-cell mode bit, combined with `fam_reg` |
| sl_pol | input | N_CELL | Per-cell polarity, 1 = active high |
| sum_term | input | N_CELL | Sum-of-products term per cell |
| oe_term | input | N_CELL | Enable product term per cell |
| oe_n | input | 1 | Global output-enable pin, active low |
| pin_in | input | N_CELL | Value present on each I/O pin |
| pin_out | output | N_CELL | Value driven toward each pin |
| pin_oe | output | N_CELL | Tri-state enable of each pin |
| fb | output | N_CELL | Feedback into the array per cell |

## Verification
The bench builds the array with the default `N_CELL` = 8. With that value there are two end cells and three middle cells in each half. Both neighbour directions and both end-cell substitutions can therefore be reached in one run. All sixteen combinations of the two global bits and the two per-cell bits are swept across every cell. Each combination is checked in both clock phases, so the clock-pin feedback of the top cell is seen at 0 and at 1.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_COMB_OUT = 2'b00,
        MODE_DED_IN   = 2'b01,
        MODE_REG      = 2'b10,
        MODE_COMB_IO  = 2'b11
    } cell_mode_e;

    typedef enum logic [1:0] {
        EN_GLOBAL,
        EN_TERM,
        EN_ON,
        EN_OFF
    } en_sel_e;

    typedef enum logic [1:0] {
        FB_QBAR,
        FB_PIN,
        FB_ZERO,
        FB_ADJ
    } fb_sel_e;

    typedef struct packed {
        logic    use_reg;
        en_sel_e en_sel;
        fb_sel_e fb_sel;
    } cell_ctl_t;

    // Effective mode once the register permit is applied.
    function automatic cell_mode_e eff_mode(input logic reg_ok,
                                            input logic fam,
                                            input logic sel);
        cell_mode_e m;
        m = cell_mode_e'({fam, sel});
        if (m == MODE_REG && !reg_ok)
            m = MODE_COMB_OUT;
        return m;
    endfunction

    function automatic fb_sel_e fb_from_code(input logic [1:0] code);
        fb_sel_e f;
        case (code)
            2'b10:   f = FB_QBAR;
            2'b11:   f = FB_PIN;
            2'b01:   f = FB_ADJ;
            default: f = FB_ZERO;
        endcase
        return f;
    endfunction

    function automatic en_sel_e en_from_mode(input cell_mode_e m);
        en_sel_e e;
        case (m)
            MODE_REG:     e = EN_GLOBAL;
            MODE_COMB_IO: e = EN_TERM;
            MODE_DED_IN:  e = EN_OFF;
            default:      e = EN_ON;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pmc_mode_dec.sv
module pmc_mode_dec
    import pmc_pkg::*;
#(
    parameter bit IS_END = 1'b0
) (
    input  logic      reg_ok,
    input  logic      fam,
    input  logic      sel,
    output cell_ctl_t ctl
);
    cell_mode_e mode;
    fb_sel_e    fsel;

    always_comb mode = eff_mode(reg_ok, fam, sel);

    generate
        if (IS_END) begin : g_end_fb
            // End cells: register permit steers the feedback select.
            always_comb fsel = fb_from_code({reg_ok, sel});
        end else begin : g_mid_fb
            always_comb fsel = fb_from_code(mode);
        end
    endgenerate

    always_comb begin
        ctl.use_reg = (mode == MODE_REG);
        ctl.en_sel  = en_from_mode(mode);
        ctl.fb_sel  = fsel;
    end
endmodule

// File: rtl/pmc_dreg.sv
module pmc_dreg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/pmc_cell.sv
module pmc_cell
    import pmc_pkg::*;
#(
    parameter bit IS_END = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic reg_ok,
    input  logic fam,
    input  logic sel,
    input  logic pol,
    input  logic sum_in,
    input  logic oe_pt,
    input  logic oe_n,
    input  logic own_pin,
    input  logic adj_pin,
    output logic pin_out,
    output logic pin_oe,
    output logic fb
);
    cell_ctl_t ctl;
    logic      q;
    logic      data;

    pmc_mode_dec #(.IS_END(IS_END)) u_dec (
        .reg_ok (reg_ok),
        .fam    (fam),
        .sel    (sel),
        .ctl    (ctl)
    );

    pmc_dreg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (sum_in),
        .q   (q)
    );

    always_comb begin
        data    = ctl.use_reg ? q : sum_in;
        pin_out = data ^ ~pol;
    end

    always_comb begin
        case (ctl.en_sel)
            EN_GLOBAL: pin_oe = ~oe_n;
            EN_TERM:   pin_oe = oe_pt;
            EN_ON:     pin_oe = 1'b1;
            default:   pin_oe = 1'b0;
        endcase
    end

    always_comb begin
        case (ctl.fb_sel)
            FB_QBAR: fb = ~q;
            FB_PIN:  fb = own_pin;
            FB_ADJ:  fb = adj_pin;
            default: fb = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmc_array.sv
module pmc_array #(
    parameter int N_CELL = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              fam_reg,
    input  logic [N_CELL-1:0] sl_mode,
    input  logic [N_CELL-1:0] sl_pol,
    input  logic [N_CELL-1:0] sum_term,
    input  logic [N_CELL-1:0] oe_term,
    input  logic              oe_n,
    input  logic [N_CELL-1:0] pin_in,
    output logic [N_CELL-1:0] pin_out,
    output logic [N_CELL-1:0] pin_oe,
    output logic [N_CELL-1:0] fb
);
    localparam int HALF = N_CELL / 2;
    localparam int LAST = N_CELL - 1;

    logic [N_CELL-1:0] adj;

    genvar i;
    generate
        for (i = 0; i < N_CELL; i++) begin : g_cell
            if (i == 0) begin : g_adj_lo
                assign adj[i] = oe_n;
            end else if (i == LAST) begin : g_adj_hi
                assign adj[i] = clk;
            end else if (i < HALF) begin : g_adj_down
                assign adj[i] = pin_in[i-1];
            end else begin : g_adj_up
                assign adj[i] = pin_in[i+1];
            end

            pmc_cell #(.IS_END((i == 0) || (i == LAST))) u_cell (
                .clk     (clk),
                .rst     (rst),
                .reg_ok  (reg_en),
                .fam     (fam_reg),
                .sel     (sl_mode[i]),
                .pol     (sl_pol[i]),
                .sum_in  (sum_term[i]),
                .oe_pt   (oe_term[i]),
                .oe_n    (oe_n),
                .own_pin (pin_in[i]),
                .adj_pin (adj[i]),
                .pin_out (pin_out[i]),
                .pin_oe  (pin_oe[i]),
                .fb      (fb[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pmc_array_chk.sv
module pmc_array_chk #(
    parameter int N_CELL = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_en,
    input logic              fam_reg,
    input logic [N_CELL-1:0] sl_mode,
    input logic [N_CELL-1:0] sl_pol,
    input logic [N_CELL-1:0] sum_term,
    input logic [N_CELL-1:0] oe_term,
    input logic              oe_n,
    input logic [N_CELL-1:0] pin_in,
    input logic [N_CELL-1:0] pin_out,
    input logic [N_CELL-1:0] pin_oe,
    input logic [N_CELL-1:0] fb
);
    genvar i;
    generate
        for (i = 0; i < N_CELL; i++) begin : g_chk
            assert_reg_capture_R1: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && reg_en && fam_reg && !sl_mode[i] && sl_pol[i])
                    |-> pin_out[i] == $past(sum_term[i]));

            assert_reg_enable_R2: assert property (@(posedge clk) disable iff (rst)
                (reg_en && fam_reg && !sl_mode[i]) |-> pin_oe[i] == !oe_n);

            assert_io_enable_R3: assert property (@(posedge clk) disable iff (rst)
                (fam_reg && sl_mode[i]) |-> pin_oe[i] == oe_term[i]);

            assert_comb_on_R4: assert property (@(posedge clk) disable iff (rst)
                (!fam_reg && !sl_mode[i]) |-> pin_oe[i]);

            assert_input_off_R5: assert property (@(posedge clk) disable iff (rst)
                (!fam_reg && sl_mode[i]) |-> !pin_oe[i]);
        end
    endgenerate

    assert_end_adj_R7: assert property (@(posedge clk) disable iff (rst)
        (!reg_en && sl_mode[0]) |-> fb[0] == oe_n);
endmodule

bind pmc_array pmc_array_chk #(.N_CELL(N_CELL)) u_pmc_chk (.*);

// File: tb/test_pmc_array.sv
module test_pmc_array;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_en = 1'b0;
    logic         fam_reg = 1'b0;
    logic [N-1:0] sl_mode = '0;
    logic [N-1:0] sl_pol = '0;
    logic [N-1:0] sum_term = '0;
    logic [N-1:0] oe_term = '0;
    logic         oe_n = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, fb;

    logic [N-1:0] qm = '0;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    pmc_array #(.N_CELL(N)) i_pmc_array (
        .clk, .rst, .reg_en, .fam_reg, .sl_mode, .sl_pol,
        .sum_term, .oe_term, .oe_n, .pin_in, .pin_out, .pin_oe, .fb
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Mode after the register permit: 10 without reg_en acts as 00.
    function automatic logic [1:0] eff(input int i);
        logic [1:0] m;
        m = {fam_reg, sl_mode[i]};
        if (m == 2'b10 && !reg_en) m = 2'b00;
        return m;
    endfunction

    function automatic logic [2:0] ref_cell(input int i, input logic ck);
        logic [1:0] m, fs;
        logic d, o, e, f, a;
        m = eff(i);
        d = (m == 2'b10) ? qm[i] : sum_term[i];
        o = sl_pol[i] ? d : ~d;
        case (m)
            2'b10: e = ~oe_n;
            2'b11: e = oe_term[i];
            2'b00: e = 1'b1;
            default: e = 1'b0;
        endcase
        fs = (i == 0 || i == N-1) ? {reg_en, sl_mode[i]} : m;
        if (i == 0) a = oe_n;
        else if (i == N-1) a = ck;
        else if (i < N/2) a = pin_in[i-1];
        else a = pin_in[i+1];
        case (fs)
            2'b10: f = ~qm[i];
            2'b11: f = pin_in[i];
            2'b01: f = a;
            default: f = 1'b0;
        endcase
        return {o, e, f};
    endfunction

    function automatic string mode_tag(input int i);
        case (eff(i))
            2'b10: return "R1,R2";
            2'b11: return "R3";
            2'b00: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_one(input string tag, input int i, input string what,
                             input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cell %0d %s: got %0b expected %0b", tag, i, what, act, exp);
        end
    endtask

    task automatic check_all(input logic ck);
        for (int i = 0; i < N; i++) begin
            logic [2:0] r;
            r = ref_cell(i, ck);
            check_one(mode_tag(i), i, "pin_out", pin_out[i], r[2]);
            check_one(mode_tag(i), i, "pin_oe", pin_oe[i], r[1]);
            check_one((i == 0 || i == N-1) ? "R7" : "R6", i, "fb", fb[i], r[0]);
        end
    endtask

    // Inputs are set just after a falling edge; check in both clock phases.
    task automatic step();
        #1 check_all(1'b0);
        @(posedge clk);
        qm = rst ? '0 : sum_term;
        #2 check_all(1'b1);
        @(negedge clk);
    endtask

    task automatic rand_data();
        sum_term = N'($urandom);
        oe_term  = N'($urandom);
        pin_in   = N'($urandom);
        oe_n     = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Settle the register under reset before checking anything.
        @(posedge clk);
        @(negedge clk);
        qm = '0;

        // R1 reset: registered, active high, sum all ones, still in reset.
        reg_en = 1'b1; fam_reg = 1'b1; sl_mode = '0; sl_pol = '1;
        sum_term = '1; oe_n = 1'b0;
        step();
        rst = 1'b0;
        // R1 capture and R2 polarity, directed patterns.
        sum_term = 8'hA5; step();
        sum_term = 8'h5A; sl_pol = 8'h0F; step();
        sum_term = 8'h00; oe_n = 1'b1; step();

        // Full sweep of {reg_en, fam_reg, sl_mode, sl_pol} on every cell.
        for (int c = 0; c < 16; c++) begin
            reg_en  = c[3];
            fam_reg = c[2];
            sl_mode = {N{c[1]}};
            sl_pol  = {N{c[0]}};
            for (int k = 0; k < 6; k++) begin
                rand_data();
                step();
            end
        end

        // Mixed per-cell configurations, occasional reset.
        for (int k = 0; k < 400; k++) begin
            reg_en  = 1'($urandom);
            fam_reg = 1'($urandom);
            sl_mode = N'($urandom);
            sl_pol  = N'($urandom);
            rst     = (($urandom % 25) == 0);
            rand_data();
            step();
        end
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule